// File: doc/BRIEF.md
# Burst-Schedule Rate-Matching Byte Buffer

This block sits between a client that moves one byte per nominal-rate strobe and a line that only transfers during the active part of a periodic time-division schedule. It holds two byte queues. The transmit queue is filled by the client at the nominal rate, without pause, and is emptied by the line at one byte per clock while the active window is open. The receive queue is filled by the line at one byte per clock during the active window, and is emptied by the client at the nominal rate. A buffer that holds one silent window's worth of nominal-rate bytes is therefore enough to carry an unbroken stream in both directions. The block needs no flow control, and it does not look at frame boundaries.

The block generates its own schedule from programmable silent and active lengths, counted in clocks. It also makes the nominal-rate strobe from a programmable clock divider. The receive reader waits until a start threshold has been reached once, so that the first silent window is covered. Sticky flags record a write into a full queue and a read from an empty queue. Both occupancy counts are brought out.

Top module: `tdd_rate_fifo`

## Requirements
- R1: After reset `active` is 0. The schedule then repeats `silent_len` clocks with `active`=0, followed by `active_len` clocks with `active`=1. Both lengths are at least 1.
- R2: `nom_stb` is high in clock k after reset release (counting from 0) exactly when k mod `nom_div` equals `nom_div`-1. `nom_div` is at least 1.
- R3: A clock edge where `nom_stb` and `tx_in_valid` are both high, and the transmit queue is not full, appends `tx_in_data`. `tx_level` shows the new count after that edge.
- R4: `tx_line_valid` is high exactly when `active` is 1 and `tx_level` is above 0. It is never high during the silent window. While it is high, `tx_line_data` is the oldest byte, and that byte is removed at the clock edge.
- R5: A clock edge with `active` and `rx_line_valid` both high, and the receive queue not full, appends `rx_line_data`. Line input offered during the silent window is ignored and leaves `rx_level` unchanged.
- R6: The receive reader is armed from the edge after the first clock in which `rx_level` >= `rx_start_thr`. It stays armed until reset. An unarmed reader never reads.
- R7: When the reader is armed at a `nom_stb` edge and the receive queue is not empty, `rx_out_valid` goes high for the next clock only. During that clock `rx_out_data` carries the oldest byte.
- R8: A write into a queue that was full before the edge (`tx_level` or `rx_level` equal to DEPTH) is dropped, and `ovf_flag` is 1 from the next clock. The flag is sticky.
- R9: An armed read at a `nom_stb` edge while the receive queue is empty returns no byte (`rx_out_valid` stays 0), and `udf_flag` is 1 from the next clock. The flag is sticky.
- R10: `clr_flags` high at an edge leaves both flags 0 after that edge, even if a new event occurs in the same clock.
- R11: Bytes leave each queue in the order they entered, with any values and with no regard to frame boundaries.
- R12: With a steady client stream and bursts matched to the cycle, the peak `tx_level` does not exceed `silent_len`/`nom_div`+1. No overflow or underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_flags | input | 1 | Clears both sticky flags |
| silent_len | input | TMR_W | Silent window length in clocks |
| active_len | input | TMR_W | Active window length in clocks |
| nom_div | input | DIV_W | Clocks per nominal-rate strobe |
| rx_start_thr | input | LW | Receive occupancy that arms the reader |
| tx_in_valid | input | 1 | Client byte offered (taken on `nom_stb`) |
| tx_in_data | input | 8 | Client transmit byte |
| tx_line_valid | output | 1 | Line takes `tx_line_data` this clock |
| tx_line_data | output | 8 | Oldest transmit byte |
| rx_line_valid | input | 1 | Line byte offered |
| rx_line_data | input | 8 | Line receive byte |
| rx_out_valid | output | 1 | Client receive byte valid |
| rx_out_data | output | 8 | Client receive byte |
| active | output | 1 | Active window flag |
| nom_stb | output | 1 | Nominal-rate strobe |
| tx_level | output | LW | Transmit queue occupancy |
| rx_level | output | LW | Receive queue occupancy |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
`active`, `nom_stb`, `tx_line_valid` and `tx_line_data` depend on registered state only, so they are valid in the same clock as the state that drives them. The levels and both flags change one edge after the stimulus that affects them. `rx_out_valid` and `rx_out_data` appear one clock after the strobe edge that reads. The bench drives inputs on the falling edge and advances its queue model by one step for each rising edge. It compares every output on the next falling edge, so each result is checked in the exact clock in which it is due. The explicit flag and clear checks are sampled on the falling edge right after the edge concerned.

// File: rtl/tdd_rate_fifo.sv
module tdd_rate_fifo #(
  parameter int DEPTH = 125,
  parameter int TMR_W = 16,
  parameter int DIV_W = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_flags,
  input  logic [TMR_W-1:0] silent_len,
  input  logic [TMR_W-1:0] active_len,
  input  logic [DIV_W-1:0] nom_div,
  input  logic [LW-1:0]    rx_start_thr,
  input  logic             tx_in_valid,
  input  logic [7:0]       tx_in_data,
  output logic             tx_line_valid,
  output logic [7:0]       tx_line_data,
  input  logic             rx_line_valid,
  input  logic [7:0]       rx_line_data,
  output logic             rx_out_valid,
  output logic [7:0]       rx_out_data,
  output logic             active,
  output logic             nom_stb,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             ovf_flag,
  output logic             udf_flag
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // window schedule
  logic [TMR_W-1:0] win_cnt;
  wire  [TMR_W-1:0] win_end = active ? active_len : silent_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      active  <= 1'b0;
    end else if (win_cnt >= win_end - 1'b1) begin
      win_cnt <= '0;
      active  <= ~active;
    end else begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  // nominal-rate strobe
  logic [DIV_W-1:0] div_cnt;
  assign nom_stb = (div_cnt >= nom_div - 1'b1);
  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= nom_stb ? '0 : div_cnt + 1'b1;
  end

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  wire tx_req  = nom_stb & tx_in_valid;
  wire tx_full = (tx_level == FULL);
  wire tx_push = tx_req & ~tx_full;
  assign tx_line_valid = active & (tx_level != '0);
  assign tx_line_data  = tx_mem[tx_rp];

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= tx_in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_level <= '0;
    end else begin
      if (tx_push)       tx_wp <= bump(tx_wp);
      if (tx_line_valid) tx_rp <= bump(tx_rp);
      case ({tx_push, tx_line_valid})
        2'b10:   tx_level <= tx_level + 1'b1;
        2'b01:   tx_level <= tx_level - 1'b1;
        default: tx_level <= tx_level;
      endcase
    end
  end

  // receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic          armed;
  wire rx_req  = active & rx_line_valid;
  wire rx_full = (rx_level == FULL);
  wire rx_push = rx_req & ~rx_full;
  wire rx_rd   = nom_stb & armed;
  wire rx_pop  = rx_rd & (rx_level != '0);

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_line_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_level <= '0; armed <= 1'b0;
      rx_out_valid <= 1'b0; rx_out_data <= '0;
    end else begin
      armed        <= armed | (rx_level >= rx_start_thr);
      rx_out_valid <= rx_pop;
      if (rx_pop) begin
        rx_out_data <= rx_mem[rx_rp];
        rx_rp       <= bump(rx_rp);
      end
      if (rx_push) rx_wp <= bump(rx_wp);
      case ({rx_push, rx_pop})
        2'b10:   rx_level <= rx_level + 1'b1;
        2'b01:   rx_level <= rx_level - 1'b1;
        default: rx_level <= rx_level;
      endcase
    end
  end

  // sticky flags
  always_ff @(posedge clk) begin
    if (!rst_n || clr_flags) begin
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_flag | (tx_req & tx_full) | (rx_req & rx_full);
      udf_flag <= udf_flag | (rx_rd & (rx_level == '0));
    end
  end

  p_tx_fall_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < $past(tx_level)) |-> $past(active));
  p_rx_rise_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level > $past(rx_level)) |-> $past(active));
  p_tx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == $past(tx_level)) || (tx_level == $past(tx_level) + 1'b1) ||
    (tx_level + 1'b1 == $past(tx_level)));
  p_no_overfill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= FULL) && (rx_level <= FULL));
  p_rx_out_after_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid |-> $past(nom_stb));
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flags) |=> ovf_flag);
  p_udf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !clr_flags) |=> udf_flag);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |=> (!ovf_flag && !udf_flag));
endmodule

// File: tb/tb_tdd_rate_fifo.sv
module tb_tdd_rate_fifo;
  localparam int CLK_P = 10;
  localparam int DEPTH = 125;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, clr_flags = 1'b0;
  logic [15:0] silent_len = 16'd40, active_len = 16'd20;
  logic [7:0]  nom_div = 8'd4;
  logic [LW-1:0] rx_start_thr = '0;
  logic tx_in_valid = 1'b0, rx_line_valid = 1'b0;
  logic [7:0] tx_in_data = '0, rx_line_data = '0;
  logic tx_line_valid, rx_out_valid, active, nom_stb, ovf_flag, udf_flag;
  logic [7:0] tx_line_data, rx_out_data;
  logic [LW-1:0] tx_level, rx_level;

  always #(CLK_P/2) clk = ~clk;

  tdd_rate_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .clr_flags(clr_flags),
    .silent_len(silent_len), .active_len(active_len), .nom_div(nom_div),
    .rx_start_thr(rx_start_thr), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
    .tx_line_valid(tx_line_valid), .tx_line_data(tx_line_data),
    .rx_line_valid(rx_line_valid), .rx_line_data(rx_line_data),
    .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
    .active(active), .nom_stb(nom_stb), .tx_level(tx_level), .rx_level(rx_level),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag));

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference
  int m_wcnt, m_div;
  bit m_act, m_arm, m_ovf, m_udf, m_rv;
  byte unsigned m_rd;
  byte unsigned txq[$], rxq[$];

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_wcnt = 0; m_div = 0; m_act = 0; m_arm = 0; m_ovf = 0; m_udf = 0; m_rv = 0; m_rd = 0;
    txq.delete(); rxq.delete();
  endtask

  task automatic compare_all();
    bit drain;
    drain = m_act && txq.size() > 0;
    chk("R1", "active", int'(active), int'(m_act));
    chk("R2", "nom_stb", int'(nom_stb), int'(m_div == int'(nom_div) - 1));
    chk("R4", "tx_line_valid", int'(tx_line_valid), int'(drain));
    if (drain) chk("R11", "tx_line_data", int'(tx_line_data), int'(txq[0]));
    chk("R3", "tx_level", int'(tx_level), txq.size());
    chk("R5", "rx_level", int'(rx_level), rxq.size());
    chk("R6/R7", "rx_out_valid", int'(rx_out_valid), int'(m_rv));
    if (m_rv) chk("R11", "rx_out_data", int'(rx_out_data), int'(m_rd));
    chk("R8", "ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk("R9", "udf_flag", int'(udf_flag), int'(m_udf));
  endtask

  task automatic model_step();
    int txn, rxn, wend;
    bit stb, ev_o, ev_u;
    txn = txq.size(); rxn = rxq.size();
    stb = (m_div == int'(nom_div) - 1);
    ev_o = 0; ev_u = 0;
    if (m_act && txn > 0) void'(txq.pop_front());
    if (stb && tx_in_valid) begin
      if (txn == DEPTH) ev_o = 1; else txq.push_back(tx_in_data);
    end
    m_rv = 0;
    if (stb && m_arm) begin
      if (rxn == 0) ev_u = 1;
      else begin m_rd = rxq.pop_front(); m_rv = 1; end
    end
    if (m_act && rx_line_valid) begin
      if (rxn == DEPTH) ev_o = 1; else rxq.push_back(rx_line_data);
    end
    if (rxn >= int'(rx_start_thr)) m_arm = 1;
    if (clr_flags) begin m_ovf = 0; m_udf = 0; end
    else begin m_ovf |= ev_o; m_udf |= ev_u; end
    wend = m_act ? int'(active_len) : int'(silent_len);
    if (m_wcnt == wend - 1) begin m_wcnt = 0; m_act = !m_act; end
    else m_wcnt++;
    m_div = stb ? 0 : m_div + 1;
  endtask

  // called on a falling edge with inputs already chosen
  task automatic cycle();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 0; clr_flags = 0; tx_in_valid = 0; rx_line_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    compare_all();
  endtask

  // steady streaming; burst of 'per_cyc' bytes each active window
  task automatic stream(int ncyc, int per_cyc, bit rnd, output int peak);
    int sent;
    byte unsigned tctr, rctr;
    sent = 0; tctr = 0; rctr = 8'h80; peak = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (int'(tx_level) > peak) peak = int'(tx_level);
      if (!m_act) sent = 0;
      tx_in_valid = rnd ? ($urandom % 4 != 0) : 1'b1;
      tx_in_data  = rnd ? 8'($urandom) : tctr;
      if (m_div == int'(nom_div) - 1 && tx_in_valid) tctr++;
      rx_line_valid = m_act && sent < per_cyc;
      rx_line_data  = rnd ? 8'($urandom) : rctr;
      if (rx_line_valid) begin sent++; rctr++; end
      cycle();
    end
    tx_in_valid = 0; rx_line_valid = 0;
  endtask

  initial begin
    int peak;
    @(negedge clk);
    do_reset();
    // reset state (R1 R3 R5 R8 R9)
    chk("R1", "reset active", int'(active), 0);
    chk("R3", "reset tx_level", int'(tx_level), 0);
    chk("R5", "reset rx_level", int'(rx_level), 0);
    chk("R8", "reset ovf", int'(ovf_flag), 0);
    chk("R9", "reset udf", int'(udf_flag), 0);

    // R12 steady stream, 10 bytes per silent window, 15 per cycle
    silent_len = 40; active_len = 20; nom_div = 4; rx_start_thr = 10;
    do_reset();
    stream(3000, 15, 0, peak);
    chk("R12", "tx peak bound", int'(peak <= 11), 1);
    chk("R12", "no ovf stream", int'(ovf_flag), 0);
    chk("R12", "no udf stream", int'(udf_flag), 0);

    // R11 R12 random bytes, random client gaps, longer windows
    silent_len = 100; active_len = 30; nom_div = 5; rx_start_thr = 20;
    do_reset();
    stream(4000, 26, 1, peak);
    chk("R12", "tx peak bound 2", int'(peak <= 21), 1);
    chk("R12", "no udf stream 2", int'(udf_flag), 0);

    // R8 transmit overflow, then R10 clear
    silent_len = 400; active_len = 10; nom_div = 1; rx_start_thr = 127;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      tx_in_valid = 1; tx_in_data = 8'(i); cycle();
    end
    chk("R8", "tx full level", int'(tx_level), DEPTH);
    chk("R8", "tx ovf set", int'(ovf_flag), 1);
    tx_in_valid = 1; clr_flags = 1; cycle();
    chk("R10", "ovf cleared despite event", int'(ovf_flag), 0);
    clr_flags = 0; tx_in_valid = 0; cycle();
    chk("R10", "ovf stays clear", int'(ovf_flag), 0);

    // R8 receive overflow during a long active window
    silent_len = 10; active_len = 200; nom_div = 8; rx_start_thr = 127;
    do_reset();
    for (int i = 0; i < 260; i++) begin
      rx_line_valid = 1; rx_line_data = 8'(i * 3); cycle();
    end
    chk("R8", "rx full level", int'(rx_level), DEPTH);
    chk("R8", "rx ovf set", int'(ovf_flag), 1);
    rx_line_valid = 0;

    // R5 silent input ignored, R9 underflow, R10 clear
    silent_len = 20; active_len = 20; nom_div = 2; rx_start_thr = 5;
    do_reset();
    for (int i = 0; i < 300; i++) begin
      rx_line_valid = (i < 60) ? (m_act && rxq.size() < 8) : !m_act;
      rx_line_data  = 8'(200 - i);
      cycle();
    end
    chk("R5", "silent input ignored", int'(rx_level), 0);
    chk("R9", "udf set", int'(udf_flag), 1);
    rx_line_valid = 0; clr_flags = 1; cycle();
    chk("R10", "udf cleared", int'(udf_flag), 0);
    clr_flags = 0; cycle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule